// File: doc/BRIEF.md
# Ring Dataflow Router Node

One node of a ring of routers that steers pixel streams around a processing element. The node receives a set of forward video channels from the previous node, a stream read from frame memory and the output of its own element. It forwards the channels to the next node and feeds up to three element input ports. Every stream is a beat of pixel data with a valid flag, a start-of-frame marker and an end-of-line marker.

Each forward channel is set either to pass the upstream traffic straight through or to carry the element's output instead, which places the element in the pipeline. Each element port picks its own source: any forward channel, the memory stream or the element's own output. Small queues on the element ports release beats only when every used port holds one, so streams that arrive skewed reach the element aligned. A ring controller writes a new routing, bypass mask and pixel quota through a configuration port. The write is staged and applied only in a cycle with no traffic, so a frame is never split across two routings. A counter of element output beats raises a one-cycle done report that carries the node index when the quota is reached.

Top module: `rdn_node`

## Requirements
- R1: While reset is held and in the first cycle after it, every output valid and the done pulse are low; the reset configuration bypasses all channels, leaves every element port unused and sets the quota to zero.
- R2: A channel whose bypass bit is 1 presents a beat that entered the node in cycle c on its output in cycle c+2, with data, start-of-frame and end-of-line unchanged; its input beats never reach another channel.
- R3: A channel whose bypass bit is 0 drops its upstream beats and carries each element output beat from cycle c in cycle c+2.
- R4: Element port p takes its source from the 3-bit field at bits [3p+2:3p] of the routing word: 0 unused (valid stays low), 1 to 3 forward channel 0 to 2, 4 the memory stream, 5 the element output. With all used ports fed in the same cycle c, the beat appears on the port in cycle c+2.
- R5: A beat leaves the used element ports only when every used port has one queued; all used ports show valid in the same cycle, and a stream that arrives early waits for the late ones in arrival order.
- R6: A configuration written while any input carries a valid beat stays pending; traffic keeps the old routing until the first cycle in which no input (forward channels, memory, element output) is valid.
- R7: When the element output beats counted since the last applied configuration reach a nonzero quota, done pulses for exactly one cycle, in the cycle after the last beat, with the node index on the node output; further beats raise no done.
- R8: Applying a configuration clears the beat count and rearms the done report; with a quota of zero, done never rises.
- R9: A write in cycle c followed by an idle cycle c+1 routes every beat presented from cycle c+2 on by the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_in_vld | input | NCH | Valid per upstream channel |
| ring_in_sof | input | NCH | Start-of-frame per upstream channel |
| ring_in_eol | input | NCH | End-of-line per upstream channel |
| ring_in_data | input | NCH*DW | Pixel per upstream channel, channel i at [i*DW +: DW] |
| mem_vld | input | 1 | Memory stream valid |
| mem_sof | input | 1 | Memory stream start-of-frame |
| mem_eol | input | 1 | Memory stream end-of-line |
| mem_data | input | DW | Memory stream pixel |
| pe_out_vld | input | 1 | Element output valid |
| pe_out_sof | input | 1 | Element output start-of-frame |
| pe_out_eol | input | 1 | Element output end-of-line |
| pe_out_data | input | DW | Element output pixel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | NPORT*3 | Source code per element port |
| cfg_bypass | input | NCH | Bypass bit per channel |
| cfg_quota | input | CNTW | Element output beats per task |
| ring_out_vld | output | NCH | Valid per downstream channel |
| ring_out_sof | output | NCH | Start-of-frame per downstream channel |
| ring_out_eol | output | NCH | End-of-line per downstream channel |
| ring_out_data | output | NCH*DW | Pixel per downstream channel |
| pe_in_vld | output | NPORT | Valid per element port |
| pe_in_sof | output | NPORT | Start-of-frame per element port |
| pe_in_eol | output | NPORT | End-of-line per element port |
| pe_in_data | output | NPORT*DW | Pixel per element port |
| done_pulse | output | 1 | One-cycle task done report |
| done_node | output | IDW | Index of this node, reported with done |

## Verification
The bench drives a memory stream that starts two cycles after the channel it pairs with; a node that forwarded each port on its own would show the two ports valid in different cycles and fail the per-beat cycle stamps. A new routing is written in the middle of traffic, so a design that switched at once would misroute the remaining beats of the frame. The quota is reached once, then the configuration is replaced after the old count has passed the new quota: a counter that was not cleared would never fire again, and one without a fired flag would pulse twice. A zero quota phase catches a done raised on an empty quota.

// File: rtl/rdn_pkg.sv
// Shared source codes for the router node.
// Assumes element port source fields are decoded against these values.
package rdn_pkg;
    localparam int SRC_NONE      = 0;
    localparam int SRC_RING_BASE = 1;

    // Code of the frame-memory stream for a given channel count.
    function automatic int src_mem(input int nch);
        return nch + SRC_RING_BASE;
    endfunction

    // Code of the element's own output.
    function automatic int src_pe(input int nch);
        return nch + SRC_RING_BASE + 1;
    endfunction

    // Number of selectable codes including "unused".
    function automatic int src_count(input int nch);
        return nch + 3;
    endfunction
endpackage

// File: rtl/rdn_fifo.sv
// Small show-ahead queue used to align one element input stream.
// Assumes DEPTH is a power of two and that the owner never pushes into a
// full queue unless it pops in the same cycle.
module rdn_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] store [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = store[rp];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) store[wp] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);  // R5
endmodule

// File: rtl/rdn_cfg.sv
// Staged configuration: a write lands in shadow registers and moves to the
// active set in the first cycle with no valid input, so a frame in flight
// keeps one routing. Assumes idle is computed from all node inputs.
module rdn_cfg #(
    parameter int NCH   = 3,
    parameter int NPORT = 3,
    parameter int SRCW  = 3,
    parameter int CNTW  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [NPORT*SRCW-1:0] wr_src,
    input  logic [NCH-1:0]        wr_bypass,
    input  logic [CNTW-1:0]       wr_quota,
    input  logic                  idle,
    output logic [NPORT*SRCW-1:0] act_src,
    output logic [NCH-1:0]        act_bypass,
    output logic [CNTW-1:0]       act_quota,
    output logic                  apply
);
    logic [NPORT*SRCW-1:0] sh_src;
    logic [NCH-1:0]        sh_bypass;
    logic [CNTW-1:0]       sh_quota;
    logic                  pending;

    assign apply = pending && idle;

    // Capture writes into the shadow set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_src    <= '0;
            sh_bypass <= '1;
            sh_quota  <= '0;
            pending   <= 1'b0;
        end else if (we) begin
            sh_src    <= wr_src;
            sh_bypass <= wr_bypass;
            sh_quota  <= wr_quota;
            pending   <= 1'b1;
        end else if (apply) begin
            pending   <= 1'b0;
        end
    end

    // Move the shadow set to the active set on an idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_src    <= '0;
            act_bypass <= '1;
            act_quota  <= '0;
        end else if (apply) begin
            act_src    <= sh_src;
            act_bypass <= sh_bypass;
            act_quota  <= sh_quota;
        end
    end

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> ($stable(act_src) && $stable(act_bypass) && $stable(act_quota)));  // R6
endmodule

// File: rtl/rdn_quota.sv
// Counts element output beats and pulses done once when the quota is met.
// Assumes clr is asserted when a new configuration becomes active.
module rdn_quota #(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            beat,
    input  logic [CNTW-1:0] quota,
    output logic            done
);
    logic [CNTW-1:0] cnt;
    logic            fired;

    // Beat counting and single done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            fired <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                cnt   <= '0;
                fired <= 1'b0;
            end else if (beat && !fired && (quota != '0)) begin
                cnt <= cnt + CNTW'(1);
                if (cnt + CNTW'(1) == quota) begin
                    done  <= 1'b1;
                    fired <= 1'b1;
                end
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R7
    AST_ZERO_QUOTA_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (quota == '0) |=> !done);  // R8
endmodule

// File: rtl/rdn_node.sv
// Ring router node: forwards NCH channels (pass-through or element output),
// feeds NPORT element ports from selectable sources through aligning queues,
// and reports task completion. Assumes the element and ring are external.
module rdn_node #(
    parameter int NCH     = 3,
    parameter int NPORT   = 3,
    parameter int DW      = 8,
    parameter int CNTW    = 16,
    parameter int QDEPTH  = 4,
    parameter int IDW     = 4,
    parameter int NODE_ID = 0,
    localparam int SRCW   = $clog2(rdn_pkg::src_count(NCH))
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ring_in_vld,
    input  logic [NCH-1:0]        ring_in_sof,
    input  logic [NCH-1:0]        ring_in_eol,
    input  logic [NCH*DW-1:0]     ring_in_data,
    input  logic                  mem_vld,
    input  logic                  mem_sof,
    input  logic                  mem_eol,
    input  logic [DW-1:0]         mem_data,
    input  logic                  pe_out_vld,
    input  logic                  pe_out_sof,
    input  logic                  pe_out_eol,
    input  logic [DW-1:0]         pe_out_data,
    input  logic                  cfg_we,
    input  logic [NPORT*SRCW-1:0] cfg_src,
    input  logic [NCH-1:0]        cfg_bypass,
    input  logic [CNTW-1:0]       cfg_quota,
    output logic [NCH-1:0]        ring_out_vld,
    output logic [NCH-1:0]        ring_out_sof,
    output logic [NCH-1:0]        ring_out_eol,
    output logic [NCH*DW-1:0]     ring_out_data,
    output logic [NPORT-1:0]      pe_in_vld,
    output logic [NPORT-1:0]      pe_in_sof,
    output logic [NPORT-1:0]      pe_in_eol,
    output logic [NPORT*DW-1:0]   pe_in_data,
    output logic                  done_pulse,
    output logic [IDW-1:0]        done_node
);
    import rdn_pkg::*;

    localparam int NSRC  = src_count(NCH);
    localparam int BW    = DW + 2;
    localparam int C_MEM = src_mem(NCH);
    localparam int C_PE  = src_pe(NCH);

    logic [NPORT*SRCW-1:0] act_src;
    logic [NCH-1:0]        act_bypass;
    logic [CNTW-1:0]       act_quota;
    logic                  apply;
    logic                  idle;

    assign idle      = !(|ring_in_vld) && !mem_vld && !pe_out_vld;
    assign done_node = IDW'(NODE_ID);

    rdn_cfg #(.NCH(NCH), .NPORT(NPORT), .SRCW(SRCW), .CNTW(CNTW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_src(cfg_src),
        .wr_bypass(cfg_bypass), .wr_quota(cfg_quota), .idle(idle),
        .act_src(act_src), .act_bypass(act_bypass), .act_quota(act_quota),
        .apply(apply)
    );

    rdn_quota #(.CNTW(CNTW)) u_quota (
        .clk(clk), .rst_n(rst_n), .clr(apply), .beat(pe_out_vld),
        .quota(act_quota), .done(done_pulse)
    );

    // ---------------- forward channel path (two register stages) ----------
    logic [NCH-1:0]    r1_vld, r1_sof, r1_eol;
    logic [NCH*DW-1:0] r1_data;
    logic              p1_vld, p1_sof, p1_eol;
    logic [DW-1:0]     p1_data;

    // First stage: capture channel and element output beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1_vld <= '0; r1_sof <= '0; r1_eol <= '0; r1_data <= '0;
            p1_vld <= 1'b0; p1_sof <= 1'b0; p1_eol <= 1'b0; p1_data <= '0;
        end else begin
            r1_vld <= ring_in_vld; r1_sof <= ring_in_sof;
            r1_eol <= ring_in_eol; r1_data <= ring_in_data;
            p1_vld <= pe_out_vld; p1_sof <= pe_out_sof;
            p1_eol <= pe_out_eol; p1_data <= pe_out_data;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Second stage: pass-through or element output per channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ring_out_vld[i] <= 1'b0;
                ring_out_sof[i] <= 1'b0;
                ring_out_eol[i] <= 1'b0;
                ring_out_data[i*DW +: DW] <= '0;
            end else if (act_bypass[i]) begin
                ring_out_vld[i] <= r1_vld[i];
                ring_out_sof[i] <= r1_sof[i];
                ring_out_eol[i] <= r1_eol[i];
                ring_out_data[i*DW +: DW] <= r1_data[i*DW +: DW];
            end else begin
                ring_out_vld[i] <= p1_vld;
                ring_out_sof[i] <= p1_sof;
                ring_out_eol[i] <= p1_eol;
                ring_out_data[i*DW +: DW] <= p1_data;
            end
        end
    end

    // ---------------- element port path (queue + output register) --------
    logic [NSRC-1:0] s_vld;
    logic [BW-1:0]   s_beat [NSRC];

    // Gather every selectable source into one indexed set.
    always_comb begin
        s_vld     = '0;
        s_beat[0] = '0;
        for (int i = 0; i < NCH; i++) begin
            s_vld[SRC_RING_BASE+i]  = ring_in_vld[i];
            s_beat[SRC_RING_BASE+i] = {ring_in_sof[i], ring_in_eol[i], ring_in_data[i*DW +: DW]};
        end
        s_vld[C_MEM]  = mem_vld;
        s_beat[C_MEM] = {mem_sof, mem_eol, mem_data};
        s_vld[C_PE]   = pe_out_vld;
        s_beat[C_PE]  = {pe_out_sof, pe_out_eol, pe_out_data};
        for (int i = C_PE + 1; i < NSRC; i++) s_beat[i] = '0;
    end

    logic [NPORT-1:0] used, q_empty, q_full, q_push, q_pop, ready;
    logic [BW-1:0]    q_rdata [NPORT];
    logic             release_all;

    assign release_all = (|used) && (&ready);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [SRCW-1:0] sel;
        assign sel      = act_src[p*SRCW +: SRCW];
        assign used[p]  = (sel != SRCW'(SRC_NONE)) && (int'(sel) < NSRC);
        assign q_push[p] = used[p] && s_vld[sel];
        assign ready[p] = !used[p] || !q_empty[p];
        assign q_pop[p] = release_all && used[p];

        rdn_fifo #(.W(BW), .DEPTH(QDEPTH)) u_q (
            .clk(clk), .rst_n(rst_n), .push(q_push[p]), .wdata(s_beat[sel]),
            .pop(q_pop[p]), .rdata(q_rdata[p]), .empty(q_empty[p]),
            .full(q_full[p])
        );

        // Port output register: present a released beat.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pe_in_vld[p] <= 1'b0;
                pe_in_sof[p] <= 1'b0;
                pe_in_eol[p] <= 1'b0;
                pe_in_data[p*DW +: DW] <= '0;
            end else begin
                pe_in_vld[p] <= q_pop[p];
                pe_in_sof[p] <= q_rdata[p][BW-1];
                pe_in_eol[p] <= q_rdata[p][BW-2];
                pe_in_data[p*DW +: DW] <= q_rdata[p][DW-1:0];
            end
        end
    end

    // Used-port mask one cycle late, to relate it to the port outputs.
    logic [NPORT-1:0] used_d;
    always_ff @(posedge clk) begin
        if (!rst_n) used_d <= '0;
        else        used_d <= used;
    end

    AST_PORTS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_in_vld == '0) || (pe_in_vld == used_d));  // R5
    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_in_vld & ~used_d) == '0);  // R4
    AST_DONE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(pe_out_vld));  // R7
endmodule

// File: tb/rdn_node_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the stimulus task predicts every output beat with its
// cycle stamp into queues; a monitor pops and compares at the falling edge.
module rdn_node_tb;
    localparam int NCH = 3, NPORT = 3, DW = 8, CNTW = 16, IDW = 4, NID = 5;

    typedef struct { int cyc; logic sof; logic eol; logic [7:0] d; } ex_t;
    typedef struct { logic sof; logic eol; logic [7:0] d; } bt_t;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [2:0]  s_rv = '0, s_rs = '0, s_re = '0;
    logic [23:0] s_rd = '0;
    logic s_mv = 0, s_ms = 0, s_me = 0; logic [7:0] s_md = '0;
    logic s_pv = 0, s_ps = 0, s_pe = 0; logic [7:0] s_pd = '0;
    logic s_we = 0; logic [8:0] s_src = '0; logic [2:0] s_byp = '0; logic [15:0] s_quota = '0;

    logic [2:0] ro_v, ro_s, ro_e; logic [23:0] ro_d;
    logic [2:0] pi_v, pi_s, pi_e; logic [23:0] pi_d;
    logic done; logic [IDW-1:0] dnode;

    rdn_node #(.NCH(NCH), .NPORT(NPORT), .DW(DW), .CNTW(CNTW), .QDEPTH(4),
               .IDW(IDW), .NODE_ID(NID)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ring_in_vld(s_rv), .ring_in_sof(s_rs), .ring_in_eol(s_re), .ring_in_data(s_rd),
        .mem_vld(s_mv), .mem_sof(s_ms), .mem_eol(s_me), .mem_data(s_md),
        .pe_out_vld(s_pv), .pe_out_sof(s_ps), .pe_out_eol(s_pe), .pe_out_data(s_pd),
        .cfg_we(s_we), .cfg_src(s_src), .cfg_bypass(s_byp), .cfg_quota(s_quota),
        .ring_out_vld(ro_v), .ring_out_sof(ro_s), .ring_out_eol(ro_e), .ring_out_data(ro_d),
        .pe_in_vld(pi_v), .pe_in_sof(pi_s), .pe_in_eol(pi_e), .pe_in_data(pi_d),
        .done_pulse(done), .done_node(dnode)
    );

    int cyc = 0, checks = 0, fails = 0, dones = 0;
    bit mon_en = 0, ended = 0;
    string cur = "R1";

    // Bench model of the active and pending configuration.
    logic [2:0] m_byp = 3'b111, p_byp; int m_src[3] = '{0, 0, 0}; int p_src[3];
    int m_quota = 0, p_quota, m_cnt = 0; bit m_fired = 0, m_pend = 0;
    bt_t mf[3][$];
    ex_t qr[3][$], qp[3][$];
    int qd[$];

    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic bit src_beat(int sel, output bt_t b);
        b = '{0, 0, 8'h00};
        if (sel >= 1 && sel <= 3) begin
            b = '{s_rs[sel-1], s_re[sel-1], s_rd[(sel-1)*8 +: 8]};
            return s_rv[sel-1];
        end
        if (sel == 4) begin b = '{s_ms, s_me, s_md}; return s_mv; end
        if (sel == 5) begin b = '{s_ps, s_pe, s_pd}; return s_pv; end
        return 0;
    endfunction

    // Predict this cycle's outputs, advance one clock, clear stimulus.
    task automatic tick();
        bit all_ok, any_used; bt_t b;
        for (int i = 0; i < 3; i++)
            if (s_rv[i] && m_byp[i]) qr[i].push_back('{cyc+2, s_rs[i], s_re[i], s_rd[i*8 +: 8]});
        if (s_pv) begin
            for (int i = 0; i < 3; i++)
                if (!m_byp[i]) qr[i].push_back('{cyc+2, s_ps, s_pe, s_pd});
            if (m_quota != 0 && !m_fired) begin
                m_cnt++;
                if (m_cnt == m_quota) begin qd.push_back(cyc+1); m_fired = 1; end
            end
        end
        all_ok = 1; any_used = 0;
        for (int p = 0; p < 3; p++)
            if (m_src[p] != 0) begin any_used = 1; if (mf[p].size() == 0) all_ok = 0; end
        if (any_used && all_ok)
            for (int p = 0; p < 3; p++)
                if (m_src[p] != 0) begin
                    b = mf[p].pop_front();
                    qp[p].push_back('{cyc+1, b.sof, b.eol, b.d});
                end
        for (int p = 0; p < 3; p++)
            if (m_src[p] != 0 && src_beat(m_src[p], b)) mf[p].push_back(b);
        if (m_pend && !(|s_rv || s_mv || s_pv)) begin
            m_byp = p_byp; m_src = p_src; m_quota = p_quota;
            m_cnt = 0; m_fired = 0; m_pend = 0;
        end
        if (s_we) begin
            p_byp = s_byp; p_quota = s_quota; m_pend = 1;
            for (int p = 0; p < 3; p++) p_src[p] = s_src[p*3 +: 3];
        end
        @(posedge clk); #1;
        s_rv = '0; s_rs = '0; s_re = '0; s_mv = 0; s_ms = 0; s_me = 0;
        s_pv = 0; s_ps = 0; s_pe = 0; s_we = 0;
    endtask

    task automatic ring(int i, logic [7:0] d, logic sof, logic eol);
        s_rv[i] = 1; s_rd[i*8 +: 8] = d; s_rs[i] = sof; s_re[i] = eol;
    endtask

    task automatic drain(string req);
        repeat (6) tick();
        for (int i = 0; i < 3; i++) begin
            chk(qr[i].size() == 0, req, "channel beats missing", qr[i].size(), 0);
            chk(qp[i].size() == 0, req, "port beats missing", qp[i].size(), 0);
        end
        chk(qd.size() == 0, req, "done missing", qd.size(), 0);
    endtask

    // Monitor: compare every produced beat against the scoreboard.
    always @(negedge clk) if (mon_en) begin
        ex_t e;
        for (int i = 0; i < 3; i++) begin
            if (ro_v[i]) begin
                if (qr[i].size() == 0) chk(0, cur, "unexpected channel beat", i, -1);
                else begin
                    e = qr[i].pop_front();
                    chk(e.cyc == cyc && e.d == ro_d[i*8 +: 8] && e.sof == ro_s[i] && e.eol == ro_e[i],
                        cur, "channel beat", {ro_s[i], ro_e[i], ro_d[i*8 +: 8]}, {e.sof, e.eol, e.d});
                end
            end
            if (pi_v[i]) begin
                if (qp[i].size() == 0) chk(0, cur, "unexpected port beat", i, -1);
                else begin
                    e = qp[i].pop_front();
                    chk(e.cyc == cyc && e.d == pi_d[i*8 +: 8] && e.sof == pi_s[i] && e.eol == pi_e[i],
                        cur, "port beat", {pi_s[i], pi_e[i], pi_d[i*8 +: 8]}, {e.sof, e.eol, e.d});
                end
            end
        end
        if (done) begin
            dones++;
            if (qd.size() == 0) chk(0, "R7", "unexpected done", cyc, -1);
            else chk(qd.pop_front() == cyc && dnode == IDW'(NID), "R7", "done cycle/node", dnode, NID);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int d0;
        // R1: outputs quiet under reset and right after it.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ro_v == 0 && pi_v == 0 && done == 0, "R1", "outputs in reset", {ro_v, pi_v, done}, 0);
        rst_n = 1;
        @(posedge clk); #1;
        @(negedge clk);
        chk(ro_v == 0 && pi_v == 0 && done == 0, "R1", "outputs after reset", {ro_v, pi_v, done}, 0);
        @(posedge clk); #1;
        mon_en = 1;

        // R2, R8: reset routing bypasses all channels, quota zero never fires.
        cur = "R2";
        for (int k = 0; k < 6; k++) begin
            ring(0, 8'h01 + 8'(k), k == 0, k == 5);
            if (k % 2 == 0) ring(1, 8'h20 + 8'(k), 0, 1);
            ring(2, 8'hE0 - 8'(k), k == 1, 0);
            s_pv = 1; s_pd = 8'h55;
            tick();
        end
        drain("R2");
        chk(dones == 0, "R8", "done with zero quota", dones, 0);

        // R9, R3, R4, R5, R7: ch1 carries element output; port0 <- ch0, port1 <- memory.
        cur = "R3/R4/R5";
        s_we = 1; s_byp = 3'b101; s_src = {3'd0, 3'd4, 3'd1}; s_quota = 16'd5;
        tick();
        tick();
        for (int k = 0; k < 10; k++) begin
            if (k < 8) begin
                ring(0, 8'h10 + 8'(k), k == 0, k == 7);
                ring(1, 8'h40 + 8'(k), 0, 0);
                ring(2, 8'h70 + 8'(k), k == 0, k[0]);
            end
            if (k >= 2) begin s_mv = 1; s_md = 8'hA0 + 8'(k); s_ms = (k == 2); s_me = (k == 9); end
            if (k % 2 == 1 || k == 8) begin s_pv = 1; s_pd = 8'hC0 + 8'(k); s_ps = (k == 1); s_pe = (k == 9); end
            tick();
        end
        drain("R5");
        chk(dones == 1, "R7", "one done for quota 5", dones, 1);

        // R6: write during traffic stays pending; old routing holds.
        cur = "R6";
        for (int k = 0; k < 5; k++) begin
            ring(2, 8'h90 + 8'(k), k == 0, k == 4);
            ring(1, 8'h30, 0, 0);
            s_pv = 1; s_pd = 8'hD0 + 8'(k);
            if (k == 1) begin s_we = 1; s_byp = 3'b100; s_src = {3'd2, 3'd3, 3'd5}; s_quota = 16'd3; end
            tick();
        end
        drain("R6");
        chk(dones == 1, "R7", "no second done", dones, 1);

        // R8, R9: new quota counts from zero; all three ports fed together.
        cur = "R8/R9";
        d0 = dones;
        for (int k = 0; k < 6; k++) begin
            s_pv = 1; s_pd = 8'h60 + 8'(k); s_ps = (k == 0); s_pe = (k == 5);
            ring(2, 8'hB0 + 8'(k), 0, k == 5);
            ring(1, 8'h08 + 8'(k), k == 0, 0);
            ring(0, 8'hFF, 0, 0);
            tick();
        end
        drain("R8");
        chk(dones - d0 == 1, "R8", "done after cleared count", dones - d0, 1);
        finish_run();
    end
endmodule